// File: doc/BRIEF.md
# Stage-2 Address Translation Walker

This block turns an intermediate physical address (IPA) into a physical address. It walks stage-2 translation tables in memory, using a 4 KB translation granule. A request carries the IPA, the access direction and the stage-2 configuration:

- the table base,
- the input-size field,
- the start-level selector,
- the access-flag-fault disable,
- the effective output size.

It also carries the input-size limit that applies when stage 1 is bypassed. The walker reads one 64-bit descriptor at a time through a simple request/response memory port. It then reports either a translation result or a typed fault.

The first-level table can be a group of up to sixteen adjacent 4 KB tables. The IPA bits above the start level's index field pick one of them. Table descriptors only move the walk down one level; they carry no permission information. A leaf descriptor goes through three checks in a fixed order: access flag, then permission, then output-address size.

The control path is a five-state machine:

- IDLE waits for `start`.
- RANGE runs the checks that need no memory read.
- ISSUE sends one descriptor read.
- WAIT holds until the read returns.
- FINISH pulses `done`.

The transitions are:

- IDLE→RANGE on start.
- RANGE→FINISH on an early fault.
- RANGE→ISSUE when the walk may begin.
- ISSUE→WAIT always.
- WAIT→ISSUE on a table descriptor.
- WAIT→FINISH on a leaf, a bad descriptor or a read error.
- FINISH→IDLE always.

Top module: `stage2_walker`

## Requirements
- R1: `start` is taken only while `busy` is low. `busy` stays high from the cycle after `start` until `done`. `done` is high for exactly one cycle. The result outputs change only in the `done` cycle and hold afterwards. After reset, `busy`, `done`, `mem_req_valid` and `fault` are all 0.
- R2: With `cfg_s1_bypass` set, an IPA ≥ 2^`cfg_oas` ends the request with `fault`=2 (address size) and no memory read. This check wins over R3.
- R3: An IPA ≥ 2^(64−`cfg_tsz`) ends the request with `fault`=1 (translation) and no memory read.
- R4: `cfg_sl0` values 0, 1 and 2 select start levels 2, 1 and 0. The value 3 gives `fault`=1 with no memory read.
- R5: The first read address is (VTTB[47:12]·4096) + c·4096 + i·8. Here c is the IPA above the start level's 9-bit index field, truncated to 4 bits. The value i is that index field. Level L indexes IPA bits [s+8:s], where s = 12 + 9·(3−L).
- R6: A descriptor with bits[1:0]=11 below level 3 is a table. The walk reads the next level at base desc[47:12]·4096 without checking permissions.
- R7: Any of the following gives `fault`=1:
  - bit0 = 0;
  - bits[1:0] = 01 at level 3;
  - bits[1:0] = 01 at level 0.

  A read returned with `mem_rsp_err` gives `fault`=5 (walk external abort).
- R8: At a leaf, AF (bit 10) = 0 with `cfg_affd` low gives `fault`=3 (access). This check comes before R9. With `cfg_affd` high, AF is not checked.
- R9: Permission bit 6 grants read and bit 7 grants write. A leaf that lacks the bit for the requested access gives `fault`=4 (permission).
- R10: After R9 passes, a leaf output address ≥ 2^`cfg_eff_ps` gives `fault`=2.
- R11: On success the outputs are:
  - `fault`=0;
  - `out_addr` = desc[47:s]·2^s;
  - `out_mask` = 2^s−1;
  - `out_ipa_base` = IPA & ~mask;
  - `out_perm` = {bit7, bit6};
  - `out_level` = the leaf level.
- R12: On any fault, `out_perm`, `out_addr`, `out_ipa_base` and `out_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk with the values on the request inputs |
| access_wr | input | 1 | 1 = write access, 0 = read access |
| ipa | input | 64 | Intermediate physical address to translate |
| cfg_vttb | input | 64 | Stage-2 table base; bits [47:12] are used |
| cfg_tsz | input | 6 | Input-size field; input range is 2^(64−tsz) |
| cfg_sl0 | input | 2 | Start-level selector |
| cfg_affd | input | 1 | 1 disables access-flag faults |
| cfg_eff_ps | input | 6 | Effective output address size in bits |
| cfg_s1_bypass | input | 1 | Stage 1 bypassed: apply the `cfg_oas` input limit |
| cfg_oas | input | 6 | Input limit in bits used under bypass |
| mem_req_valid | output | 1 | Descriptor read request, one cycle |
| mem_req_addr | output | PA_W | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor read data valid |
| mem_rsp_err | input | 1 | Descriptor read failed |
| mem_rsp_data | input | 64 | Descriptor value |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid, one-cycle pulse |
| fault | output | 3 | 0 none, 1 translation, 2 address size, 3 access, 4 permission, 5 walk abort |
| out_addr | output | PA_W | Output block/page base address |
| out_ipa_base | output | 64 | IPA aligned down to the block/page size |
| out_mask | output | 64 | Offset mask of the block/page |
| out_perm | output | 2 | [1] write allowed, [0] read allowed |
| out_level | output | 2 | Level of the leaf descriptor |

## Verification
Two pairs of checks can fall due in the same evaluation cycle.

The first pair is the bypass input limit and the input-size limit. Both run in RANGE, so the bench gives an IPA that breaks both limits at once. It expects the address-size code and no memory read.

The second pair is the three leaf checks, which are all evaluated in the WAIT cycle that accepts the descriptor. The bench returns leaves that fail the access flag and the permission together. It also returns leaves that fail the permission and the output size together. In each case it judges the reported code against the fixed priority of the checks.

// File: rtl/s2w_pkg.sv
package s2w_pkg;

    localparam int GRAIN_LG  = 12;
    localparam int STRIDE    = 9;
    localparam int DESC_LG   = 3;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_XLATE      = 3'd1,
        FLT_ADDR_SIZE  = 3'd2,
        FLT_ACCESS     = 3'd3,
        FLT_PERM       = 3'd4,
        FLT_WALK_ABORT = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RANGE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } walk_state_e;

    typedef enum logic [1:0] {
        DK_TABLE,
        DK_LEAF,
        DK_BAD
    } desc_kind_e;

    // Bit position of the lowest address bit translated at a level.
    function automatic logic [5:0] level_shift(input logic [1:0] lvl);
        return 6'(GRAIN_LG + STRIDE * (3 - int'(lvl)));
    endfunction

endpackage

// File: rtl/s2w_start_sel.sv
module s2w_start_sel
    import s2w_pkg::*;
#(
    parameter int CONCAT_W = 4
) (
    input  logic [1:0]          sl0,
    input  logic [63:0]         ipa,
    output logic [1:0]          start_level,
    output logic                sl0_bad,
    output logic [CONCAT_W-1:0] concat_idx
);
    localparam int IDX_SPAN = STRIDE;

    logic [5:0]  top_shift;
    logic [63:0] above;

    always_comb begin
        sl0_bad     = 1'b0;
        start_level = 2'd0;
        unique case (sl0)
            2'd0:    start_level = 2'd2;
            2'd1:    start_level = 2'd1;
            2'd2:    start_level = 2'd0;
            default: sl0_bad     = 1'b1;
        endcase
    end

    assign top_shift  = level_shift(start_level);
    assign above      = ipa >> (7'(top_shift) + 7'(IDX_SPAN));
    assign concat_idx = above[CONCAT_W-1:0];

endmodule

// File: rtl/s2w_level_idx.sv
module s2w_level_idx
    import s2w_pkg::*;
(
    input  logic [1:0]         level,
    input  logic [63:0]        ipa,
    output logic [5:0]         shift,
    output logic [STRIDE-1:0]  index,
    output logic [63:0]        mask
);
    logic [63:0] shifted;

    assign shift   = level_shift(level);
    assign shifted = ipa >> shift;
    assign index   = shifted[STRIDE-1:0];
    assign mask    = (64'd1 << shift) - 64'd1;

endmodule

// File: rtl/s2w_desc_eval.sv
module s2w_desc_eval
    import s2w_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic [63:0]     desc,
    input  logic [1:0]      level,
    input  logic [5:0]      shift,
    input  logic            wr,
    input  logic            affd,
    input  logic [5:0]      eff_ps,
    output desc_kind_e      kind,
    output fault_e          leaf_fault,
    output logic [PA_W-1:0] leaf_addr,
    output logic [PA_W-1:0] next_base,
    output logic [1:0]      perm
);
    localparam int AF_BIT = 10;
    localparam int RD_BIT = 6;
    localparam int WR_BIT = 7;

    logic [PA_W-1:0] blk_mask;
    logic            allowed;

    assign blk_mask  = (PA_W'(1) << shift) - PA_W'(1);
    assign leaf_addr = desc[PA_W-1:0] & ~blk_mask;
    assign next_base = {desc[PA_W-1:GRAIN_LG], {GRAIN_LG{1'b0}}};
    assign perm      = {desc[WR_BIT], desc[RD_BIT]};
    assign allowed   = wr ? desc[WR_BIT] : desc[RD_BIT];

    always_comb begin
        if (!desc[0])
            kind = DK_BAD;
        else if (level == 2'd3)
            kind = desc[1] ? DK_LEAF : DK_BAD;
        else if (desc[1])
            kind = DK_TABLE;
        else if (level == 2'd0)
            kind = DK_BAD;
        else
            kind = DK_LEAF;
    end

    // Leaf checks in priority order: access flag, permission, output size.
    always_comb begin
        if (!desc[AF_BIT] && !affd)
            leaf_fault = FLT_ACCESS;
        else if (!allowed)
            leaf_fault = FLT_PERM;
        else if ((leaf_addr >> eff_ps) != '0)
            leaf_fault = FLT_ADDR_SIZE;
        else
            leaf_fault = FLT_NONE;
    end

endmodule

// File: rtl/stage2_walker.sv
module stage2_walker
    import s2w_pkg::*;
#(
    parameter int PA_W     = 48,
    parameter int CONCAT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            access_wr,
    input  logic [63:0]     ipa,
    input  logic [63:0]     cfg_vttb,
    input  logic [5:0]      cfg_tsz,
    input  logic [1:0]      cfg_sl0,
    input  logic            cfg_affd,
    input  logic [5:0]      cfg_eff_ps,
    input  logic            cfg_s1_bypass,
    input  logic [5:0]      cfg_oas,
    output logic            mem_req_valid,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic            mem_rsp_err,
    input  logic [63:0]     mem_rsp_data,
    output logic            busy,
    output logic            done,
    output logic [2:0]      fault,
    output logic [PA_W-1:0] out_addr,
    output logic [63:0]     out_ipa_base,
    output logic [63:0]     out_mask,
    output logic [1:0]      out_perm,
    output logic [1:0]      out_level
);
    localparam int TBL_LG = GRAIN_LG;

    walk_state_e state_q, state_d;

    // Latched request
    logic [63:0]     ipa_q;
    logic            wr_q;
    logic [PA_W-1:0] vttb_q;
    logic [5:0]      tsz_q;
    logic [1:0]      sl0_q;
    logic            affd_q;
    logic [5:0]      effps_q;
    logic            byp_q;
    logic [5:0]      oas_q;

    // Walk state
    logic [1:0]      level_q;
    logic [PA_W-1:0] base_q;

    // Results
    fault_e          res_fault;
    logic [PA_W-1:0] res_addr;
    logic [63:0]     res_base;
    logic [63:0]     res_mask;
    logic [1:0]      res_perm;
    logic [1:0]      res_level;

    // Sub-block wires
    logic [1:0]          start_level;
    logic                sl0_bad;
    logic [CONCAT_W-1:0] concat_idx;
    logic [5:0]          cur_shift;
    logic [STRIDE-1:0]   cur_index;
    logic [63:0]         cur_mask;
    desc_kind_e          dkind;
    fault_e              leaf_fault;
    logic [PA_W-1:0]     leaf_addr;
    logic [PA_W-1:0]     next_base;
    logic [1:0]          leaf_perm;

    logic [6:0] in_size;
    logic       oas_hit;
    logic       tsz_hit;
    logic       early_fault;

    s2w_start_sel #(.CONCAT_W(CONCAT_W)) u_start (
        .sl0         (sl0_q),
        .ipa         (ipa_q),
        .start_level (start_level),
        .sl0_bad     (sl0_bad),
        .concat_idx  (concat_idx)
    );

    s2w_level_idx u_lvl (
        .level (level_q),
        .ipa   (ipa_q),
        .shift (cur_shift),
        .index (cur_index),
        .mask  (cur_mask)
    );

    s2w_desc_eval #(.PA_W(PA_W)) u_desc (
        .desc       (mem_rsp_data),
        .level      (level_q),
        .shift      (cur_shift),
        .wr         (wr_q),
        .affd       (affd_q),
        .eff_ps     (effps_q),
        .kind       (dkind),
        .leaf_fault (leaf_fault),
        .leaf_addr  (leaf_addr),
        .next_base  (next_base),
        .perm       (leaf_perm)
    );

    // Checks that need no memory read
    assign in_size     = 7'd64 - 7'(tsz_q);
    assign oas_hit     = byp_q && ((ipa_q >> oas_q) != 64'd0);
    assign tsz_hit     = (ipa_q >> in_size) != 64'd0;
    assign early_fault = oas_hit || tsz_hit || sl0_bad;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RANGE;
            ST_RANGE:  state_d = early_fault ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid)
                    state_d = (mem_rsp_err || dkind != DK_TABLE) ? ST_FINISH : ST_ISSUE;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request latch, walk datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipa_q     <= '0;
            wr_q      <= 1'b0;
            vttb_q    <= '0;
            tsz_q     <= '0;
            sl0_q     <= '0;
            affd_q    <= 1'b0;
            effps_q   <= '0;
            byp_q     <= 1'b0;
            oas_q     <= '0;
            level_q   <= '0;
            base_q    <= '0;
            res_fault <= FLT_NONE;
            res_addr  <= '0;
            res_base  <= '0;
            res_mask  <= '0;
            res_perm  <= '0;
            res_level <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ipa_q   <= ipa;
                        wr_q    <= access_wr;
                        vttb_q  <= cfg_vttb[PA_W-1:0];
                        tsz_q   <= cfg_tsz;
                        sl0_q   <= cfg_sl0;
                        affd_q  <= cfg_affd;
                        effps_q <= cfg_eff_ps;
                        byp_q   <= cfg_s1_bypass;
                        oas_q   <= cfg_oas;
                    end
                end
                ST_RANGE: begin
                    if (early_fault) begin
                        res_fault <= oas_hit ? FLT_ADDR_SIZE : FLT_XLATE;
                        res_addr  <= '0;
                        res_base  <= '0;
                        res_mask  <= '0;
                        res_perm  <= '0;
                        res_level <= '0;
                    end else begin
                        level_q <= start_level;
                        base_q  <= {vttb_q[PA_W-1:TBL_LG], {TBL_LG{1'b0}}}
                                   + (PA_W'(concat_idx) << TBL_LG);
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_err && dkind == DK_TABLE) begin
                            base_q  <= next_base;
                            level_q <= level_q + 2'd1;
                        end else if (!mem_rsp_err && dkind == DK_LEAF
                                     && leaf_fault == FLT_NONE) begin
                            res_fault <= FLT_NONE;
                            res_addr  <= leaf_addr;
                            res_base  <= ipa_q & ~cur_mask;
                            res_mask  <= cur_mask;
                            res_perm  <= leaf_perm;
                            res_level <= level_q;
                        end else begin
                            if (mem_rsp_err)
                                res_fault <= FLT_WALK_ABORT;
                            else if (dkind == DK_BAD)
                                res_fault <= FLT_XLATE;
                            else
                                res_fault <= leaf_fault;
                            res_addr  <= '0;
                            res_base  <= '0;
                            res_mask  <= '0;
                            res_perm  <= '0;
                            res_level <= level_q;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        done          = (state_q == ST_FINISH);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = base_q + (PA_W'(cur_index) << DESC_LG);
        fault         = res_fault;
        out_addr      = res_addr;
        out_ipa_base  = res_base;
        out_mask      = res_mask;
        out_perm      = res_perm;
        out_level     = res_level;
    end

endmodule

// File: rtl/s2w_checker.sv
module s2w_checker #(
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            mem_req_valid,
    input logic [2:0]      fault,
    input logic [PA_W-1:0] out_addr,
    input logic [63:0]     out_ipa_base,
    input logic [63:0]     out_mask,
    input logic [1:0]      out_perm
);

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_result_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_addr) |-> done);

    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    assert_fault_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 3'd0) |-> (out_perm == 2'd0 && out_addr == '0 && out_mask == 64'd0));

    assert_base_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == 3'd0) |-> ((out_ipa_base & out_mask) == 64'd0));

endmodule

bind stage2_walker s2w_checker #(.PA_W(PA_W)) u_s2w_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .fault         (fault),
    .out_addr      (out_addr),
    .out_ipa_base  (out_ipa_base),
    .out_mask      (out_mask),
    .out_perm      (out_perm)
);

// File: tb/stage2_walker_test.sv
`timescale 1ns/1ps
module stage2_walker_test;

    localparam int PA_W = 48;
    localparam int NV   = 16;
    localparam logic [63:0] VTTB = 64'h4000_0000;

    typedef struct packed {
        logic [63:0] ipa;
        logic        wr;
        logic [5:0]  tsz;
        logic [1:0]  sl0;
        logic        affd;
        logic [5:0]  eff_ps;
        logic        byp;
        logic [5:0]  oas;
        logic [2:0]  nfetch;
        logic [2:0]  err_at;
        logic [47:0] a0;
        logic [47:0] a1;
        logic [47:0] a2;
        logic [63:0] d0;
        logic [63:0] d1;
        logic [63:0] d2;
        logic [2:0]  x_fault;
        logic [47:0] x_addr;
        logic [63:0] x_base;
        logic [63:0] x_mask;
        logic [1:0]  x_perm;
        logic [1:0]  x_level;
    } vec_t;

    // ipa, wr, tsz, sl0, affd, eff_ps, byp, oas, nfetch, err_at,
    // a0, a1, a2, d0, d1, d2, fault, addr, ipa_base, mask, perm, level
    localparam vec_t VECS [NV] = '{
        // 0: three-level page walk
        '{64'h4020_3456, 1'b0, 6'd24, 2'd1, 1'b0, 6'd40, 1'b0, 6'd0, 3'd3, 3'd7,
          48'h4000_0008, 48'h5000_0008, 48'h6000_0018,
          64'h5000_0003, 64'h6000_0003, 64'h7_1234_54C3,
          3'd0, 48'h7_1234_5000, 64'h4020_3000, 64'hFFF, 2'd3, 2'd3},
        // 1: level-1 block in second concatenated table
        '{64'h80_C000_1234, 1'b0, 6'd24, 2'd1, 1'b0, 6'd40, 1'b0, 6'd0, 3'd1, 3'd7,
          48'h4000_1018, 48'h0, 48'h0, 64'h8000_0441, 64'h0, 64'h0,
          3'd0, 48'h8000_0000, 64'h80_C000_0000, 64'h3FFF_FFFF, 2'd1, 2'd1},
        // 2: write to read-only block
        '{64'h80_C000_1234, 1'b1, 6'd24, 2'd1, 1'b0, 6'd40, 1'b0, 6'd0, 3'd1, 3'd7,
          48'h4000_1018, 48'h0, 48'h0, 64'h8000_0441, 64'h0, 64'h0,
          3'd4, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 3: AF clear and permission fail together: access wins
        '{64'h80_C000_1234, 1'b1, 6'd24, 2'd1, 1'b0, 6'd40, 1'b0, 6'd0, 3'd1, 3'd7,
          48'h4000_1018, 48'h0, 48'h0, 64'h8000_0041, 64'h0, 64'h0,
          3'd3, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 4: AF clear but AF faults disabled
        '{64'h80_C000_1234, 1'b0, 6'd24, 2'd1, 1'b1, 6'd40, 1'b0, 6'd0, 3'd1, 3'd7,
          48'h4000_1018, 48'h0, 48'h0, 64'h8000_0041, 64'h0, 64'h0,
          3'd0, 48'h8000_0000, 64'h80_C000_0000, 64'h3FFF_FFFF, 2'd1, 2'd1},
        // 5: output beyond effective size
        '{64'h80_C000_1234, 1'b0, 6'd24, 2'd1, 1'b0, 6'd31, 1'b0, 6'd0, 3'd1, 3'd7,
          48'h4000_1018, 48'h0, 48'h0, 64'h8000_0441, 64'h0, 64'h0,
          3'd2, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 6: permission and output size both fail: permission wins
        '{64'h80_C000_1234, 1'b1, 6'd24, 2'd1, 1'b0, 6'd31, 1'b0, 6'd0, 3'd1, 3'd7,
          48'h4000_1018, 48'h0, 48'h0, 64'h8000_0441, 64'h0, 64'h0,
          3'd4, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 7: IPA beyond input size
        '{64'h100_0000_0000, 1'b0, 6'd24, 2'd1, 1'b0, 6'd40, 1'b0, 6'd0, 3'd0, 3'd7,
          48'h0, 48'h0, 48'h0, 64'h0, 64'h0, 64'h0,
          3'd1, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 8: bypass limit only
        '{64'h1_0000_0000, 1'b0, 6'd24, 2'd1, 1'b0, 6'd40, 1'b1, 6'd32, 3'd0, 3'd7,
          48'h0, 48'h0, 48'h0, 64'h0, 64'h0, 64'h0,
          3'd2, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 9: bypass limit and input size both broken
        '{64'h100_0000_0000, 1'b0, 6'd24, 2'd1, 1'b0, 6'd40, 1'b1, 6'd32, 3'd0, 3'd7,
          48'h0, 48'h0, 48'h0, 64'h0, 64'h0, 64'h0,
          3'd2, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 10: invalid first descriptor
        '{64'h4020_3456, 1'b0, 6'd24, 2'd1, 1'b0, 6'd40, 1'b0, 6'd0, 3'd1, 3'd7,
          48'h4000_0008, 48'h0, 48'h0, 64'h0, 64'h0, 64'h0,
          3'd1, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 11: reserved encoding at level 3
        '{64'h4020_3456, 1'b0, 6'd24, 2'd1, 1'b0, 6'd40, 1'b0, 6'd0, 3'd3, 3'd7,
          48'h4000_0008, 48'h5000_0008, 48'h6000_0018,
          64'h5000_0003, 64'h6000_0003, 64'h7_1234_54C1,
          3'd1, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 12: start level 0, block encoding there is reserved
        '{64'h80_0000_0000, 1'b0, 6'd16, 2'd2, 1'b0, 6'd48, 1'b0, 6'd0, 3'd1, 3'd7,
          48'h4000_0008, 48'h0, 48'h0, 64'h441, 64'h0, 64'h0,
          3'd1, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 13: start level 2, fourth concatenated table, block
        '{64'hC020_0000, 1'b1, 6'd32, 2'd0, 1'b0, 6'd48, 1'b0, 6'd0, 3'd1, 3'd7,
          48'h4000_3008, 48'h0, 48'h0, 64'hAB_CDE0_04C1, 64'h0, 64'h0,
          3'd0, 48'hAB_CDE0_0000, 64'hC020_0000, 64'h1F_FFFF, 2'd3, 2'd2},
        // 14: read error on second fetch
        '{64'h4020_3456, 1'b0, 6'd24, 2'd1, 1'b0, 6'd40, 1'b0, 6'd0, 3'd2, 3'd1,
          48'h4000_0008, 48'h5000_0008, 48'h0,
          64'h5000_0003, 64'h6000_0003, 64'h0,
          3'd5, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0},
        // 15: reserved start-level selector
        '{64'h1000, 1'b0, 6'd24, 2'd3, 1'b0, 6'd40, 1'b0, 6'd0, 3'd0, 3'd7,
          48'h0, 48'h0, 48'h0, 64'h0, 64'h0, 64'h0,
          3'd1, 48'h0, 64'h0, 64'h0, 2'd0, 2'd0}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start;
    logic            access_wr;
    logic [63:0]     ipa;
    logic [63:0]     cfg_vttb;
    logic [5:0]      cfg_tsz;
    logic [1:0]      cfg_sl0;
    logic            cfg_affd;
    logic [5:0]      cfg_eff_ps;
    logic            cfg_s1_bypass;
    logic [5:0]      cfg_oas;
    logic            mem_req_valid;
    logic [PA_W-1:0] mem_req_addr;
    logic            mem_rsp_valid;
    logic            mem_rsp_err;
    logic [63:0]     mem_rsp_data;
    logic            busy;
    logic            done;
    logic [2:0]      fault;
    logic [PA_W-1:0] out_addr;
    logic [63:0]     out_ipa_base;
    logic [63:0]     out_mask;
    logic [1:0]      out_perm;
    logic [1:0]      out_level;

    int n_checks = 0;
    int n_fail   = 0;
    string vtag [NV];

    always #5 clk = ~clk;

    stage2_walker #(.PA_W(PA_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .access_wr(access_wr), .ipa(ipa),
        .cfg_vttb(cfg_vttb), .cfg_tsz(cfg_tsz), .cfg_sl0(cfg_sl0), .cfg_affd(cfg_affd),
        .cfg_eff_ps(cfg_eff_ps), .cfg_s1_bypass(cfg_s1_bypass), .cfg_oas(cfg_oas),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .done(done), .fault(fault), .out_addr(out_addr),
        .out_ipa_base(out_ipa_base), .out_mask(out_mask), .out_perm(out_perm),
        .out_level(out_level)
    );

    task automatic chk(input string what, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int v);
        vec_t t;
        int   k;
        int   guard;
        logic pend;
        logic [63:0] pdata;
        logic perr;
        t = VECS[v];
        k = 0;
        pend = 1'b0;
        pdata = '0;
        perr = 1'b0;
        @(negedge clk);
        ipa           = t.ipa;
        access_wr     = t.wr;
        cfg_vttb      = VTTB;
        cfg_tsz       = t.tsz;
        cfg_sl0       = t.sl0;
        cfg_affd      = t.affd;
        cfg_eff_ps    = t.eff_ps;
        cfg_s1_bypass = t.byp;
        cfg_oas       = t.oas;
        start         = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 100) begin
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pdata;
                mem_rsp_err   = perr;
                pend = 1'b0;
            end
            if (mem_req_valid) begin
                // R5: descriptor address of each fetch
                if (k < 3)
                    chk($sformatf("vec %0d fetch %0d addr", v, k), "R5", 64'(mem_req_addr),
                        64'(k == 0 ? t.a0 : (k == 1 ? t.a1 : t.a2)));
                pdata = (k == 0) ? t.d0 : ((k == 1) ? t.d1 : t.d2);
                perr  = (k == int'(t.err_at));
                pend  = 1'b1;
                k++;
            end
            @(negedge clk);
            guard++;
        end
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        chk($sformatf("vec %0d done", v), "R1", 64'(done), 64'd1);
        chk($sformatf("vec %0d fetch count", v), vtag[v], 64'(k), 64'(t.nfetch));
        chk($sformatf("vec %0d fault", v), vtag[v], 64'(fault), 64'(t.x_fault));
        if (t.x_fault == 3'd0) begin
            chk($sformatf("vec %0d out_addr", v), "R11", 64'(out_addr), 64'(t.x_addr));
            chk($sformatf("vec %0d out_ipa_base", v), "R11", out_ipa_base, t.x_base);
            chk($sformatf("vec %0d out_mask", v), "R11", out_mask, t.x_mask);
            chk($sformatf("vec %0d out_perm", v), "R11", 64'(out_perm), 64'(t.x_perm));
            chk($sformatf("vec %0d out_level", v), "R11", 64'(out_level), 64'(t.x_level));
        end else begin
            chk($sformatf("vec %0d fault perm", v), "R12", 64'(out_perm), 64'd0);
            chk($sformatf("vec %0d fault addr", v), "R12", 64'(out_addr), 64'd0);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        vtag[0]  = "R6";  vtag[1]  = "R5";  vtag[2]  = "R9";  vtag[3]  = "R8";
        vtag[4]  = "R8";  vtag[5]  = "R10"; vtag[6]  = "R10"; vtag[7]  = "R3";
        vtag[8]  = "R2";  vtag[9]  = "R2";  vtag[10] = "R7";  vtag[11] = "R7";
        vtag[12] = "R4";  vtag[13] = "R4";  vtag[14] = "R7";  vtag[15] = "R4";

        rst_n = 1'b0; start = 1'b0; access_wr = 1'b0; ipa = '0; cfg_vttb = '0;
        cfg_tsz = '0; cfg_sl0 = '0; cfg_affd = 1'b0; cfg_eff_ps = '0;
        cfg_s1_bypass = 1'b0; cfg_oas = '0;
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("reset busy", "R1", 64'(busy), 64'd0);
        chk("reset done", "R1", 64'(done), 64'd0);
        chk("reset req", "R1", 64'(mem_req_valid), 64'd0);
        chk("reset fault", "R1", 64'(fault), 64'd0);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R1: results hold after a walk and done stays low
        run_vec(13);
        repeat (5) @(negedge clk);
        chk("held done", "R1", 64'(done), 64'd0);
        chk("held busy", "R1", 64'(busy), 64'd0);
        chk("held out_addr", "R1", 64'(out_addr), 64'hAB_CDE0_0000);
        chk("held out_level", "R1", 64'(out_level), 64'd2);

        // R1: busy high the cycle after start, before any result
        @(negedge clk);
        ipa = 64'h1000; cfg_tsz = 6'd24; cfg_sl0 = 2'd3; cfg_s1_bypass = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("busy after start", "R1", 64'(busy), 64'd1);
        chk("no early done", "R1", 64'(done), 64'd0);
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule